// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDRAM device from power-up to a usable state once reset is released. It drives a command strobe with a 2-bit command code and a mode-data field. First it issues a lone NOP. Then it waits out the long power-up interval. After that it steps through a fixed list: one precharge, a run of auto-refresh commands, and a final mode-register set. Successive list commands are spaced by a minimum gap.

The mode data is worked out from the CAS latency field of the timing word and the bus-width bit of the group word. A nonzero override value replaces that calculation. The block also presents the timing word that a downstream controller applies. During the sequence the auto-refresh field of that word is held at zero, and the full configured value appears only when the sequence is complete. All delays are cycle counts derived from the clock frequency and rounded up.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held, cmd_valid, cmd_code, cmd_mode, timing_out and done are all zero.
- R2: The first strobe comes on the first clock edge after reset is released. It carries code NOP (0) with cmd_mode zero. The command codes are NOP=0, PRECHARGE=1, REFRESH=2 and MODE_SET=3.
- R3: The second strobe follows the first by PWR_CYC = ceil(PWRUP_NS * CLK_HZ / 1e9) cycles, with a minimum of one.
- R4: After the NOP, the strobes run in this order: one PRECHARGE, then exactly N_REF (default 8) REFRESH, then one MODE_SET. No further strobe follows.
- R5: Successive list strobes are GAP_CYC = ceil(GAP_NS * CLK_HZ / 1e9) cycles apart.
- R6: cmd_valid is a one-cycle pulse for each command, and the code and mode data are valid in that same cycle.
- R7: With no override, the mode data comes from bits [2:0] of timing_cfg. A value of 2 gives 0x40. Any other value counts as latency 3 and gives 0x60 (32-bit bus).
- R8: When bit WIDE_BIT (default 9) of grp_cfg is set, the bus is 16 bits wide and the mode data is halved: 0x20 for latency 2 and 0x30 for latency 3.
- R9: A nonzero mode_override is used as the mode data for every list command in place of the calculated value.
- R10: From the first cycle after reset until done rises, timing_out equals the captured timing_cfg with its 2-bit refresh field (bits REF_LSB+1:REF_LSB, default 4:3) forced to zero. From the cycle done rises onward, timing_out equals the captured timing_cfg in full.
- R11: done rises GAP_CYC cycles after the MODE_SET strobe and stays high until reset. Changes on timing_cfg, grp_cfg or mode_override after the first post-reset edge have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timing_cfg | input | TW | Timing configuration word; [2:0] CAS latency, refresh field at REF_LSB |
| grp_cfg | input | GW | Group configuration word; bit WIDE_BIT selects a 16-bit bus |
| mode_override | input | MW | Mode data override, used when nonzero |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_code | output | 2 | Command code (NOP/PRECHARGE/REFRESH/MODE_SET) |
| cmd_mode | output | MW | Mode data attached to the command |
| timing_out | output | TW | Timing word for the controller, refresh gated until done |
| done | output | 1 | Sequence complete, sticky until reset |

## Verification
A corrupted step counter shows at the ports within one command gap. The next strobe then arrives early or late, carries the wrong code, or the count of REFRESH commands before MODE_SET is off. A wrong captured configuration shows on the first list strobe as a bad cmd_mode value, or on timing_out, whose refresh field is checked on every cycle up to done and whose full value is checked at done. The sweep covers every CAS field value, both bus widths and both override cases, so each row of the mode-data table is observed.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int CLK_HZ   = 100_000_000,
  parameter int PWRUP_NS = 200_000,
  parameter int GAP_NS   = 80,
  parameter int N_REF    = 8,
  parameter int TW       = 32,
  parameter int GW       = 32,
  parameter int MW       = 8,
  parameter int REF_LSB  = 3,
  parameter int WIDE_BIT = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] timing_cfg,
  input  logic [GW-1:0] grp_cfg,
  input  logic [MW-1:0] mode_override,
  output logic          cmd_valid,
  output logic [1:0]    cmd_code,
  output logic [MW-1:0] cmd_mode,
  output logic [TW-1:0] timing_out,
  output logic          done
);
  localparam longint PWR_L   = (longint'(PWRUP_NS) * CLK_HZ + 999_999_999) / 1_000_000_000;
  localparam longint GAP_L   = (longint'(GAP_NS) * CLK_HZ + 999_999_999) / 1_000_000_000;
  localparam int     PWR_CYC = (PWR_L < 1) ? 1 : int'(PWR_L);
  localparam int     GAP_CYC = (GAP_L < 1) ? 1 : int'(GAP_L);
  localparam int     MAXW    = (PWR_CYC > GAP_CYC) ? PWR_CYC : GAP_CYC;
  localparam int     CW      = $clog2(MAXW + 1);
  localparam int     N_CMDS  = N_REF + 2;
  localparam int     IW      = $clog2(N_CMDS + 1);

  localparam logic [1:0] C_NOP = 2'd0, C_PRE = 2'd1, C_REF = 2'd2, C_MRS = 2'd3;
  localparam logic [TW-1:0] REF_MASK = TW'(3) << REF_LSB;

  typedef enum logic [1:0] {P_START, P_LIST, P_FIN} phase_t;

  phase_t        phase;
  logic [CW-1:0] wcnt;
  logic [IW-1:0] idx;
  logic [TW-1:0] lat_timing;
  logic [MW-1:0] lat_mode;
  logic [MW-1:0] calc_mode;
  logic [1:0]    next_code;

  wire unused_ok = &{1'b0, grp_cfg};

  wire          cl2     = (timing_cfg[2:0] == 3'd2);
  wire [MW-1:0] base_md = cl2 ? MW'(8'h40) : MW'(8'h60);
  assign calc_mode = (mode_override != '0) ? mode_override
                   : (grp_cfg[WIDE_BIT] ? (base_md >> 1) : base_md);

  assign next_code = (idx == '0) ? C_PRE
                   : (idx == IW'(N_CMDS - 1)) ? C_MRS : C_REF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= P_START;
      wcnt       <= '0;
      idx        <= '0;
      lat_timing <= '0;
      lat_mode   <= '0;
      cmd_valid  <= 1'b0;
      cmd_code   <= C_NOP;
      cmd_mode   <= '0;
      timing_out <= '0;
      done       <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      case (phase)
        P_START: begin
          lat_timing <= timing_cfg;
          lat_mode   <= calc_mode;
          timing_out <= timing_cfg & ~REF_MASK;
          cmd_valid  <= 1'b1;
          cmd_code   <= C_NOP;
          cmd_mode   <= '0;
          wcnt       <= CW'(PWR_CYC - 1);
          idx        <= '0;
          phase      <= P_LIST;
        end
        P_LIST: begin
          if (wcnt != '0) begin
            wcnt <= wcnt - 1'b1;
          end else if (idx < IW'(N_CMDS)) begin
            cmd_valid <= 1'b1;
            cmd_code  <= next_code;
            cmd_mode  <= lat_mode;
            wcnt      <= CW'(GAP_CYC - 1);
            idx       <= idx + 1'b1;
          end else begin
            timing_out <= lat_timing;
            done       <= 1'b1;
            phase      <= P_FIN;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int CLK_HZ  = 100_000_000,
  parameter int GAP_NS  = 80,
  parameter int TW      = 32,
  parameter int MW      = 8,
  parameter int REF_LSB = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [1:0]    cmd_code,
  input logic [MW-1:0] cmd_mode,
  input logic [TW-1:0] timing_out,
  input logic          done
);
  localparam longint GAP_L   = (longint'(GAP_NS) * CLK_HZ + 999_999_999) / 1_000_000_000;
  localparam int     GAP_CYC = (GAP_L < 1) ? 1 : int'(GAP_L);

  logic       seen;
  logic [31:0] since;
  logic       mrs_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen     <= 1'b0;
      since    <= '0;
      mrs_seen <= 1'b0;
    end else begin
      if (cmd_valid) begin
        seen  <= 1'b1;
        since <= 32'd1;
        if (cmd_code == 2'd3) mrs_seen <= 1'b1;
      end else if (since < 32'(GAP_CYC)) begin
        since <= since + 1;
      end
    end
  end

  assert_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && seen) |-> (since >= 32'(GAP_CYC)));

  assert_refresh_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (timing_out[REF_LSB +: 2] == 2'b00));

  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  assert_quiet_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid);

  assert_nothing_after_mrs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_seen && cmd_valid) |-> 1'b0);

  assert_nop_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 2'd0) |-> (cmd_mode == '0));

  assert_timing_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done) && done) |-> $stable(timing_out));
endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .CLK_HZ(CLK_HZ), .GAP_NS(GAP_NS), .TW(TW), .MW(MW), .REF_LSB(REF_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .cmd_mode(cmd_mode), .timing_out(timing_out), .done(done)
);

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;
  localparam int PWRUP_NS = 1000;
  localparam int GAP_NS   = 80;
  localparam int PWR_CYC  = (PWRUP_NS + 9) / 10;
  localparam int GAP_CYC  = (GAP_NS + 9) / 10;
  localparam int N_STRB   = 11;
  localparam int DONE_AT  = 1 + PWR_CYC + 9 * GAP_CYC + GAP_CYC;
  localparam logic [31:0] RMASK = 32'h0000_0018;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] timing_cfg = '0;
  logic [31:0] grp_cfg = '0;
  logic [7:0]  mode_override = '0;
  logic        cmd_valid;
  logic [1:0]  cmd_code;
  logic [7:0]  cmd_mode;
  logic [31:0] timing_out;
  logic        done;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sdram_init_seq #(.PWRUP_NS(PWRUP_NS), .GAP_NS(GAP_NS)) uut (
    .clk(clk), .rst_n(rst_n), .timing_cfg(timing_cfg), .grp_cfg(grp_cfg),
    .mode_override(mode_override), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_mode(cmd_mode), .timing_out(timing_out), .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_case(input int cas, input int w16, input logic [7:0] ovr);
    logic [31:0] tval;
    logic [7:0]  exp_mode;
    int          n_strb;
    int          st_time [N_STRB];
    logic [1:0]  st_code [N_STRB];
    logic [7:0]  st_mode [N_STRB];
    int          first_done;
    int          tbad;
    int          dbad;
    tval = (32'h5A3C_9E18 & ~32'h7) | 32'(cas);
    if (ovr != 0) exp_mode = ovr;
    else begin
      exp_mode = (cas == 2) ? 8'h40 : 8'h60;
      if (w16 != 0) exp_mode = exp_mode >> 1;
    end
    @(negedge clk);
    rst_n = 1'b0;
    timing_cfg = tval;
    grp_cfg = (w16 != 0) ? 32'h0000_0200 : 32'hFFFF_FDFF;
    mode_override = ovr;
    repeat (3) @(negedge clk);
    check(!cmd_valid && cmd_code == 0 && cmd_mode == 0 && timing_out == 0 && !done,
          "R1 reset state", {cmd_valid, cmd_code, done}, 0);
    rst_n = 1'b1;
    n_strb = 0; first_done = -1; tbad = 0; dbad = 0;
    for (int n = 1; n <= DONE_AT + 40; n++) begin
      @(negedge clk);
      if (n == 50) begin
        timing_cfg = ~tval;
        grp_cfg = ~grp_cfg;
        mode_override = 8'hC3;
      end
      if (cmd_valid) begin
        if (n_strb < N_STRB) begin
          st_time[n_strb] = n; st_code[n_strb] = cmd_code; st_mode[n_strb] = cmd_mode;
        end
        n_strb++;
      end
      if (done && first_done < 0) first_done = n;
      if (first_done >= 0 && !done) dbad++;
      if (n < DONE_AT) begin
        if (timing_out != (tval & ~RMASK)) tbad++;
      end else if (timing_out != tval) tbad++;
    end
    check(n_strb == N_STRB, "R4 strobe count", n_strb, N_STRB);
    if (n_strb >= N_STRB) begin
      for (int k = 0; k < N_STRB; k++) begin
        int         et;
        logic [1:0] ec;
        logic [7:0] em;
        et = (k == 0) ? 1 : 1 + PWR_CYC + (k - 1) * GAP_CYC;
        ec = (k == 0) ? 2'd0 : (k == 1) ? 2'd1 : (k == N_STRB - 1) ? 2'd3 : 2'd2;
        em = (k == 0) ? 8'h00 : exp_mode;
        if (k == 0) check(st_time[k] == et, "R2 first strobe time", st_time[k], et);
        else if (k == 1) check(st_time[k] == et, "R3 power-up wait", st_time[k], et);
        else check(st_time[k] == et, "R5 command gap / R6 single pulse", st_time[k], et);
        check(st_code[k] == ec, "R4 command order", st_code[k], ec);
        if (ovr != 0) check(st_mode[k] == em, "R9 override mode", st_mode[k], em);
        else if (w16 != 0) check(st_mode[k] == em, "R8 16-bit mode", st_mode[k], em);
        else check(st_mode[k] == em, "R7 CAS mode", st_mode[k], em);
      end
    end
    check(first_done == DONE_AT, "R11 done time", first_done, DONE_AT);
    check(dbad == 0, "R11 done sticky", dbad, 0);
    check(tbad == 0, "R10 timing_out gating", tbad, 0);
    check(timing_out == tval, "R11 inputs ignored after start", timing_out, tval);
  endtask

  initial begin
    for (int ov = 0; ov < 2; ov++)
      for (int w = 0; w < 2; w++)
        for (int c = 0; c < 8; c++)
          run_case(c, w, (ov != 0) ? 8'h5A : 8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule